// File: doc/BRIEF.md
# Circuit Reservation Switch Controller

This block is the electronic control plane of one node in a circuit-switched optical torus. Control packets arrive on five input ports: north, east, south, west and local injection. A setup packet is routed dimension-ordered, X first and then Y. If the output it needs is free, that output is reserved for the input the packet came in on. The block then sets the ring drive bits of the node's 4x4 ring switch for the turn, and forwards the packet unchanged on the chosen output. A teardown packet follows the circuit its input owns, releases it and is forwarded on that output. Acknowledge packets are routed like setups but never reserve anything.

Each input has a single-entry holding slot. A setup whose output is taken waits in that slot, and `in_ready` stays low, until the output frees up. The ring drive uses inverted sense: a bit is 1 (powered, pass-through) unless a reserved circuit turns through that ring, in which case it is 0.

Top module: `csw_switch_ctrl`

## Requirements
- R1: After reset every ring drive bit is 1, every `out_valid` bit is 0, every `in_ready` bit is 1 and no output is reserved.
- R2: Packet byte: bits [7:6] kind (01 setup, 10 teardown, 11 acknowledge), bits [5:3] destination X, bits [2:0] destination Y. Port index 0 north, 1 east, 2 south, 3 west, 4 local. Route: east if X > node X, west if X < node X, else north if Y > node Y, south if Y < node Y, else local.
- R3: A setup captured on clock edge e whose output is free reserves that output for its input and appears unchanged on that output with `out_valid` high for the single cycle after edge e+2.
- R4: Ring bit index for a reserved turn (input to output): E to N 0, E to S 1, W to N 2, W to S 3, N to E 4, N to W 5, S to E 6, S to W 7. That bit goes to 0 from edge e+1, one cycle before the packet is forwarded. Straight, U-turn and local paths change no ring bit.
- R5: A setup whose output is reserved is not forwarded. It stays in its slot with `in_ready` low and is retried each cycle until the output is free.
- R6: A teardown on an input that owns an output (the lowest-numbered one if several) frees it, restores its ring bit to 1, and is forwarded on that output with R3 timing.
- R7: A teardown on an input that owns nothing is discarded: no output and no change to any reservation or ring bit.
- R8: An acknowledge is forwarded on its routed output even when that output is reserved, and it changes no reservation.
- R9: When several packets want one output in the same cycle, the lowest-numbered input wins and the others wait. A teardown releasing an output wins over a setup that wants it in the same cycle, and that setup is granted one cycle later.
- R10: A packet of kind 00 is discarded with no output and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-input packet valid |
| in_pkt | input | 40 | Per-input packet, input i in bits [8i+7:8i] |
| in_ready | output | 5 | Per-input slot empty |
| out_valid | output | 5 | Per-output forward strobe |
| out_pkt | output | 40 | Per-output forwarded packet |
| ring_drive | output | 8 | Ring enables, 1 = pass-through |

## Verification
Two things can fall in the same cycle: a teardown releasing an output and a setup retrying for that same output. This happens in two directed cases. In one, a west setup is parked behind an east circuit and the east teardown then arrives. In the other, a south and a west setup race for north, and the south circuit is then torn down. The check is that the teardown leaves first, the ring bits of the waiting setup turn on exactly one cycle after the release, and the setup follows one cycle behind the teardown. The race case also shows priority through the ring bits, because the straight winner leaves them all set.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;
  localparam int CRD_W  = 3;
  localparam int KIND_W = 2;
  localparam int PKT_W  = KIND_W + 2 * CRD_W;
  localparam int NRING  = 8;
  localparam int RIDX_W = $clog2(NRING);

  localparam logic [PORT_W-1:0] P_N = 3'd0;
  localparam logic [PORT_W-1:0] P_E = 3'd1;
  localparam logic [PORT_W-1:0] P_S = 3'd2;
  localparam logic [PORT_W-1:0] P_W = 3'd3;
  localparam logic [PORT_W-1:0] P_L = 3'd4;

  typedef enum logic [KIND_W-1:0] {
    K_NONE  = 2'd0,
    K_SETUP = 2'd1,
    K_TEAR  = 2'd2,
    K_ACK   = 2'd3
  } kind_e;

  function automatic kind_e pkt_kind(input logic [PKT_W-1:0] p);
    return kind_e'(p[PKT_W-1 -: KIND_W]);
  endfunction

  // X first, then Y, else eject locally
  function automatic logic [PORT_W-1:0] dor_port(input logic [PKT_W-1:0] p,
                                                 input logic [CRD_W-1:0] hx,
                                                 input logic [CRD_W-1:0] hy);
    logic [CRD_W-1:0] dx, dy;
    dx = p[2*CRD_W-1:CRD_W];
    dy = p[CRD_W-1:0];
    if (dx > hx)      return P_E;
    else if (dx < hx) return P_W;
    else if (dy > hy) return P_N;
    else if (dy < hy) return P_S;
    else              return P_L;
  endfunction

  // {turns, ring index}; X inputs use rings 0..3, Y inputs rings 4..7
  function automatic logic [RIDX_W:0] turn_ring(input logic [PORT_W-1:0] src,
                                                input logic [PORT_W-1:0] dst);
    if ((src == P_E || src == P_W) && (dst == P_N || dst == P_S))
      return {1'b1, 1'b0, src == P_W, dst == P_S};
    if ((src == P_N || src == P_S) && (dst == P_E || dst == P_W))
      return {1'b1, 1'b1, src == P_S, dst == P_W};
    return '0;
  endfunction
endpackage

// File: rtl/csw_in_slot.sv
module csw_in_slot import csw_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PKT_W-1:0] in_pkt,
  input  logic             take,
  output logic             in_ready,
  output logic             slot_v,
  output logic [PKT_W-1:0] slot_pkt
);
  logic             full_q;
  logic [PKT_W-1:0] pkt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      pkt_q  <= '0;
    end else if (full_q && take) begin
      full_q <= 1'b0;
    end else if (!full_q && in_valid) begin
      full_q <= 1'b1;
      pkt_q  <= in_pkt;
    end
  end

  assign in_ready = !full_q;
  assign slot_v   = full_q;
  assign slot_pkt = pkt_q;

  // a parked packet stays put until it is taken
  assert_hold_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    full_q && !take |=> full_q && $stable(pkt_q));
endmodule

// File: rtl/csw_grant.sv
module csw_grant import csw_pkg::*; #(
  parameter int HOME_X = 3,
  parameter int HOME_Y = 4
) (
  input  logic              slot_v   [NPORT],
  input  logic [PKT_W-1:0]  slot_pkt [NPORT],
  input  logic              own_v    [NPORT],
  input  logic [PORT_W-1:0] own_id   [NPORT],
  output logic              take     [NPORT],
  output logic              win_v    [NPORT],
  output logic [PORT_W-1:0] win_src  [NPORT]
);
  localparam logic [CRD_W-1:0] HX = CRD_W'(HOME_X);
  localparam logic [CRD_W-1:0] HY = CRD_W'(HOME_Y);

  logic [PORT_W-1:0] tgt  [NPORT];
  logic              elig [NPORT];
  logic              drop [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      tgt[i]  = dor_port(slot_pkt[i], HX, HY);
      elig[i] = 1'b0;
      drop[i] = 1'b0;
      if (slot_v[i]) begin
        case (pkt_kind(slot_pkt[i]))
          K_SETUP: elig[i] = !own_v[tgt[i]];
          K_TEAR: begin
            drop[i] = 1'b1;
            for (int o = NPORT - 1; o >= 0; o--) begin
              if (own_v[o] && own_id[o] == PORT_W'(i)) begin
                tgt[i]  = PORT_W'(o);
                elig[i] = 1'b1;
                drop[i] = 1'b0;
              end
            end
          end
          K_ACK:   elig[i] = 1'b1;
          default: drop[i] = 1'b1;
        endcase
      end
    end
    // fixed priority per output: lowest input index wins
    for (int o = 0; o < NPORT; o++) begin
      win_v[o]   = 1'b0;
      win_src[o] = '0;
      for (int i = NPORT - 1; i >= 0; i--) begin
        if (elig[i] && tgt[i] == PORT_W'(o)) begin
          win_v[o]   = 1'b1;
          win_src[o] = PORT_W'(i);
        end
      end
    end
    for (int i = 0; i < NPORT; i++)
      take[i] = drop[i] ||
                (elig[i] && win_v[tgt[i]] && win_src[tgt[i]] == PORT_W'(i));
  end
endmodule

// File: rtl/csw_resv_table.sv
module csw_resv_table import csw_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_v    [NPORT],
  input  logic [PORT_W-1:0] win_src  [NPORT],
  input  logic [PKT_W-1:0]  slot_pkt [NPORT],
  output logic              own_v    [NPORT],
  output logic [PORT_W-1:0] own_id   [NPORT],
  output logic [NRING-1:0]  ring_drive
);
  logic              own_v_q  [NPORT];
  logic [PORT_W-1:0] own_id_q [NPORT];
  logic              own_v_n  [NPORT];
  logic [PORT_W-1:0] own_id_n [NPORT];
  logic [NRING-1:0]  ring_q, ring_n;
  logic [NPORT-1:0]  own_vec, win_vec;
  logic [RIDX_W:0]   tr;

  always_comb begin
    ring_n = '1;
    tr     = '0;
    for (int o = 0; o < NPORT; o++) begin
      own_v_n[o]  = own_v_q[o];
      own_id_n[o] = own_id_q[o];
      if (win_v[o]) begin
        case (pkt_kind(slot_pkt[win_src[o]]))
          K_SETUP: begin own_v_n[o] = 1'b1; own_id_n[o] = win_src[o]; end
          K_TEAR:  own_v_n[o] = 1'b0;
          default: ;
        endcase
      end
      if (own_v_n[o]) begin
        tr = turn_ring(own_id_n[o], PORT_W'(o));
        if (tr[RIDX_W]) ring_n[tr[RIDX_W-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '1;
      for (int o = 0; o < NPORT; o++) begin
        own_v_q[o]  <= 1'b0;
        own_id_q[o] <= '0;
      end
    end else begin
      ring_q <= ring_n;
      for (int o = 0; o < NPORT; o++) begin
        own_v_q[o]  <= own_v_n[o];
        own_id_q[o] <= own_id_n[o];
      end
    end
  end

  always_comb
    for (int o = 0; o < NPORT; o++) begin
      own_vec[o] = own_v_q[o];
      win_vec[o] = win_v[o];
    end

  assign own_v      = own_v_q;
  assign own_id     = own_id_q;
  assign ring_drive = ring_q;

  // each turning ring belongs to one reserved output
  assert_ring_vs_owned_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(~ring_q) <= $countones(own_vec));
  // ring bits move only on the edge that grants a packet
  assert_ring_moves_on_grant_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ring_q) |-> $past(|win_vec));

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // a setup is never granted an output that is already held
    assert_no_steal_R5: assert property (@(posedge clk) disable iff (rst)
      win_v[o] && pkt_kind(slot_pkt[win_src[o]]) == K_SETUP |-> !own_v_q[o]);
    // a granted teardown leaves its output free
    assert_tear_frees_R6: assert property (@(posedge clk) disable iff (rst)
      win_v[o] && pkt_kind(slot_pkt[win_src[o]]) == K_TEAR |=> !own_v_q[o]);
  end
endmodule

// File: rtl/csw_switch_ctrl.sv
module csw_switch_ctrl import csw_pkg::*; #(
  parameter int HOME_X = 3,
  parameter int HOME_Y = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT*PKT_W-1:0] in_pkt,
  output logic [NPORT-1:0]       in_ready,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*PKT_W-1:0] out_pkt,
  output logic [NRING-1:0]       ring_drive
);
  logic              slot_v   [NPORT];
  logic [PKT_W-1:0]  slot_pkt [NPORT];
  logic              take     [NPORT];
  logic              win_v    [NPORT];
  logic [PORT_W-1:0] win_src  [NPORT];
  logic              own_v    [NPORT];
  logic [PORT_W-1:0] own_id   [NPORT];
  logic [NPORT-1:0]  fwd_v;
  logic [PKT_W-1:0]  fwd_pkt  [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_slot
    csw_in_slot i_slot (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid[i]),
      .in_pkt   (in_pkt[i*PKT_W +: PKT_W]),
      .take     (take[i]),
      .in_ready (in_ready[i]),
      .slot_v   (slot_v[i]),
      .slot_pkt (slot_pkt[i])
    );
  end

  csw_grant #(.HOME_X(HOME_X), .HOME_Y(HOME_Y)) i_grant (
    .slot_v   (slot_v),
    .slot_pkt (slot_pkt),
    .own_v    (own_v),
    .own_id   (own_id),
    .take     (take),
    .win_v    (win_v),
    .win_src  (win_src)
  );

  csw_resv_table i_table (
    .clk        (clk),
    .rst        (rst),
    .win_v      (win_v),
    .win_src    (win_src),
    .slot_pkt   (slot_pkt),
    .own_v      (own_v),
    .own_id     (own_id),
    .ring_drive (ring_drive)
  );

  // stage 1 lines up with the ring update, stage 2 drives the ports
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_v     <= '0;
      out_valid <= '0;
      out_pkt   <= '0;
      for (int o = 0; o < NPORT; o++) fwd_pkt[o] <= '0;
    end else begin
      out_valid <= fwd_v;
      for (int o = 0; o < NPORT; o++) begin
        fwd_v[o]                   <= win_v[o];
        fwd_pkt[o]                 <= slot_pkt[win_src[o]];
        out_pkt[o*PKT_W +: PKT_W]  <= fwd_pkt[o];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out_chk
    // a forwarded setup always leaves behind a live reservation
    assert_fwd_setup_owned_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && pkt_kind(out_pkt[o*PKT_W +: PKT_W]) == K_SETUP |-> own_v[o]);
  end
endmodule

// File: tb/test_csw_switch_ctrl.sv
module test_csw_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HX = 3;
  localparam int HY = 4;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] in_valid = '0;
  logic [39:0]   in_pkt = '0;
  logic [NP-1:0] in_ready;
  logic [NP-1:0] out_valid;
  logic [39:0]   out_pkt;
  logic [7:0]    ring_drive;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  bit m_v  [NP];
  int m_id [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  csw_switch_ctrl #(.HOME_X(HX), .HOME_Y(HY)) i_csw_switch_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
    .in_ready(in_ready), .out_valid(out_valid), .out_pkt(out_pkt),
    .ring_drive(ring_drive));

  function automatic logic [7:0] mk(input int k, input int x, input int y);
    return {2'(k), 3'(x), 3'(y)};
  endfunction

  function automatic int route(input logic [7:0] p);
    int dx = int'(p[5:3]);
    int dy = int'(p[2:0]);
    if (dx > HX) return 1;
    if (dx < HX) return 3;
    if (dy > HY) return 0;
    if (dy < HY) return 2;
    return 4;
  endfunction

  function automatic int ring_of(input int s, input int d);
    case ({s[3:0], d[3:0]})
      {4'd1, 4'd0}: return 0;
      {4'd1, 4'd2}: return 1;
      {4'd3, 4'd0}: return 2;
      {4'd3, 4'd2}: return 3;
      {4'd0, 4'd1}: return 4;
      {4'd0, 4'd3}: return 5;
      {4'd2, 4'd1}: return 6;
      {4'd2, 4'd3}: return 7;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [7:0] model_ring();
    logic [7:0] r = 8'hFF;
    for (int o = 0; o < NP; o++)
      if (m_v[o] && ring_of(m_id[o], o) >= 0) r[ring_of(m_id[o], o)] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input int p, input logic [7:0] pk);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_pkt[p*8 +: 8] = pk;
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  // one packet alone; exp_o < 0 means nothing leaves
  task automatic txn(input int p, input logic [7:0] pk, input int exp_o,
                     input logic [7:0] exp_ring, input string tag);
    drive(p, pk);
    step();
    chk({tag, " ring at e+1"}, 40'(ring_drive), 40'(exp_ring));
    chk({tag, " no early forward"}, 40'(out_valid), 40'd0);
    step();
    chk({tag, " out_valid at e+2"}, 40'(out_valid), exp_o < 0 ? 40'd0 : 40'(5'd1 << exp_o));
    if (exp_o >= 0) chk({tag, " out_pkt"}, 40'(out_pkt[exp_o*8 +: 8]), 40'(pk));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 ring", 40'(ring_drive), 40'hFF);
    chk("R1 out_valid", 40'(out_valid), 40'd0);
    chk("R1 in_ready", 40'(in_ready), 40'h1F);

    // R2 R3: west input heading east goes straight, no ring change
    txn(3, mk(1, 6, 4), 1, 8'hFF, "R2 R3 straight east");
    txn(3, mk(2, 0, 0), 1, 8'hFF, "R6 teardown east");
    // R4: east input turning north clears ring 0 at e+1
    txn(1, mk(1, 3, 6), 0, 8'hFE, "R4 turn E->N");

    // R5: west setup for north is blocked while east owns north
    drive(3, mk(1, 3, 7));
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 blocked no forward", 40'(out_valid), 40'd0);
      chk("R5 blocked in_ready low", 40'(in_ready[3]), 40'd0);
    end
    // R9 R6: east teardown released in the cycle the west setup retries
    drive(1, mk(2, 0, 0));
    step();
    chk("R6 ring restored", 40'(ring_drive), 40'hFF);
    step();
    chk("R9 teardown first", 40'(out_valid), 40'h01);
    chk("R9 teardown pkt", 40'(out_pkt[7:0]), 40'(mk(2, 0, 0)));
    chk("R9 R4 W->N ring one cycle later", 40'(ring_drive), 40'hFB);
    step();
    chk("R5 retried setup forwarded", 40'(out_valid), 40'h01);
    chk("R5 retried setup pkt", 40'(out_pkt[7:0]), 40'(mk(1, 3, 7)));
    chk("R5 slot freed", 40'(in_ready[3]), 40'd1);
    txn(3, mk(2, 0, 0), 0, 8'hFF, "R6 teardown west");

    // R9: south and west race for north; south (lower index) wins
    @(negedge clk);
    in_valid[2] = 1'b1; in_pkt[2*8 +: 8] = mk(1, 3, 7);
    in_valid[3] = 1'b1; in_pkt[3*8 +: 8] = mk(1, 3, 7);
    @(negedge clk);
    in_valid = '0;
    step();
    chk("R9 race winner is straight south", 40'(ring_drive), 40'hFF);
    step();
    chk("R9 race forward", 40'(out_valid), 40'h01);
    chk("R9 race loser waits", 40'(in_ready[3]), 40'd0);
    drive(2, mk(2, 0, 0));
    step();
    chk("R9 loser still waiting", 40'(ring_drive), 40'hFF);
    step();
    chk("R9 south teardown out", 40'(out_pkt[7:0]), 40'(mk(2, 0, 0)));
    chk("R9 west now owns north", 40'(ring_drive), 40'hFB);
    step();
    chk("R9 west setup out", 40'(out_valid), 40'h01);
    txn(3, mk(2, 0, 0), 0, 8'hFF, "R6 teardown west 2");

    // R4 local path touches no ring
    txn(4, mk(1, HX, HY), 4, 8'hFF, "R4 local eject");
    txn(4, mk(2, 0, 0), 4, 8'hFF, "R6 local teardown");
    // R7 teardown with no circuit
    txn(1, mk(2, 0, 0), -1, 8'hFF, "R7 orphan teardown");
    // R8 acknowledge through a reserved output
    txn(4, mk(1, 6, 1), 1, 8'hFF, "R3 inject east");
    txn(2, mk(3, 5, 0), 1, 8'hFF, "R8 ack on reserved output");
    // R10 kind 00 dropped
    txn(3, mk(0, 6, 4), -1, 8'hFF, "R10 kind 00 dropped");
    txn(4, mk(2, 0, 0), 1, 8'hFF, "R8 reservation kept after ack");
    // R2 west and south routes with turns
    txn(0, mk(1, 1, 2), 3, 8'hDF, "R2 R4 N->W");
    txn(0, mk(2, 0, 0), 3, 8'hFF, "R6 teardown N->W");
    txn(1, mk(1, 3, 0), 2, 8'hFD, "R2 R4 E->S");
    txn(1, mk(2, 0, 0), 2, 8'hFF, "R6 teardown E->S");

    // constrained random against the bench model
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int o = 0; o < NP; o++) begin m_v[o] = 1'b0; m_id[o] = 0; end
    step();
    chk("R1 second reset ring", 40'(ring_drive), 40'hFF);
    for (int n = 0; n < 400; n++) begin
      int p = int'($urandom % NP);
      int k = int'($urandom % 4);
      logic [7:0] pk = mk(k, int'($urandom % 8), int'($urandom % 8));
      int eo = -1;
      if (k == 1) begin
        eo = route(pk);
        if (m_v[eo]) continue;
        m_v[eo] = 1'b1; m_id[eo] = p;
      end else if (k == 2) begin
        for (int o = NP - 1; o >= 0; o--) if (m_v[o] && m_id[o] == p) eo = o;
        if (eo >= 0) m_v[eo] = 1'b0;
      end else if (k == 3) begin
        eo = route(pk);
      end
      chk("R5 ready before random send", 40'(in_ready[p]), 40'd1);
      txn(p, pk, eo, model_ring(), "R2 R3 R4 R6 R7 R8 R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule